// File: doc/BRIEF.md
# Indexed Voice Register File

This block holds the per-voice control words of a multi-voice synthesiser and makes them reachable through a four-location I/O window. The host first writes a voice number into the voice select location, then a function code into the function select location. The two data locations then give access to the 16-bit register named by that voice and function. An access can move a whole word, or a single byte, with the data location's address LSB choosing the lane.

Writing and reading use separate function codes. Codes 0x00 to 0x0D write a per-voice register, and the same code with bit 7 set (0x80 to 0x8D) reads it back. Function 0x0E writes an active-voice count and 0x8E reads it. Function 0x4C writes a global run register. While bit 0 of that register is 0, the chip is held in reset: per-voice writes are dropped, and writing a 0 into that bit also restores the voice count to 0xCD. Any other read code on a data location returns all ones. Reads are combinational from the current selection. Writes take effect at the clock edge that samples `wr_en`.

Top module: `voice_regfile`

## Requirements
- R1: After a hardware reset both select latches read 0x0000, every stored word is 0x0000, the voice count is 0xCD and the run bit is 0.
- R2: A write to `port_sel`=0 stores wdata[7:0] as the voice select, and a read there returns it zero-extended. Only its low 5 bits choose the voice, so voice select 0x25 reaches the same words as voice 5.
- R3: A write to `port_sel`=1 stores wdata[7:0] as the function select, and a read there returns it zero-extended. Write codes 0x00–0x0D and read codes 0x80–0x8D address the same 14 words per voice through bits 3:0.
- R4: With `word_acc`=1, a data-location write with a write code stores all 16 bits of wdata, and a read with the matching read code returns them, for every voice including voice 31 and function 0x0D.
- R5: A byte write (`word_acc`=0) to the low data location (`port_sel`=2) replaces bits 7:0 of the word with wdata[7:0] and keeps bits 15:8.
- R6: A byte write to the high data location (`port_sel`=3) moves wdata[7:0] into bits 15:8 and keeps bits 7:0.
- R7: A byte read returns bits 7:0 of the word from the low data location and bits 15:8 from the high one, placed in rdata[7:0] with rdata[15:8] zero.
- R8: While the run bit is 0, per-voice writes leave every stored word unchanged.
- R9: Function 0x0E on a data location writes wdata[7:0] into the voice count whatever the run bit is. Function 0x8E reads the count as 0x00XX from either data location.
- R10: Function 0x4C on a data location loads wdata[0] into the run bit. When wdata[0] is 0, the voice count is also set to 0xCD.
- R11: A data-location read under any function code outside 0x80–0x8E returns 0xFFFF. This includes write codes, 0x8F and 0x4C.
- R12: A write to one voice and function leaves every other stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| port_sel | input | 2 | Window location: 0 voice select, 1 function select, 2 data low, 3 data high |
| word_acc | input | 1 | 1 for a 16-bit access, 0 for a byte access on the lane picked by port_sel[0] |
| wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rdata | output | 16 | Read data for the current location and selection |

## Verification
Each write lands at the rising edge where `wr_en` is high. Because reads are combinational, the new value appears on `rdata` right after that edge, and nothing else is in the path. The bench therefore drives each write on a falling edge and drops the strobe on the next falling edge. Read checks set `port_sel`, `word_acc` and the selection on a falling edge and sample `rdata` one time unit later, well clear of any rising edge. The in-RTL properties check each register update one cycle after the write strobe is sampled.

// File: rtl/voice_regfile.sv
module voice_regfile #(
  parameter int         NUM_VOICES = 32,
  parameter int         NUM_FUNCS  = 14,
  parameter int         DATA_W     = 16,
  parameter int         SEL_W      = 8,
  parameter logic [7:0] CNT_FUNC   = 8'h0E,
  parameter logic [7:0] RUN_FUNC   = 8'h4C,
  parameter logic [7:0] CNT_INIT   = 8'hCD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        port_sel,
  input  logic              word_acc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int VOICE_W = $clog2(NUM_VOICES);
  localparam int FUNC_W  = $clog2(NUM_FUNCS);
  localparam int LANE_W  = DATA_W / 2;
  localparam int HI_W    = SEL_W - FUNC_W;
  localparam logic [HI_W-1:0]  RD_HI   = HI_W'(1) << (HI_W - 1);
  localparam logic [SEL_W-1:0] CNT_RD  = CNT_FUNC | (SEL_W'(1) << (SEL_W - 1));

  logic [SEL_W-1:0]  vsel_q, fsel_q;
  logic [LANE_W-1:0] count_q;
  logic              run_q;
  logic [DATA_W-1:0] mem [NUM_VOICES][NUM_FUNCS];

  logic [VOICE_W-1:0] vidx;
  logic [FUNC_W-1:0]  fidx;
  logic               fidx_ok, wr_code, rd_code, is_data, hi_lane;
  logic               voice_we, cnt_we, run_we;
  logic [DATA_W-1:0]  cur_word, merged;

  assign is_data  = port_sel[1];
  assign hi_lane  = port_sel[0];
  assign vidx     = vsel_q[VOICE_W-1:0];
  assign fidx     = fsel_q[FUNC_W-1:0];
  assign fidx_ok  = 32'(fidx) < NUM_FUNCS;
  assign wr_code  = (fsel_q[SEL_W-1:FUNC_W] == '0)    && fidx_ok;
  assign rd_code  = (fsel_q[SEL_W-1:FUNC_W] == RD_HI) && fidx_ok;
  assign cur_word = fidx_ok ? mem[vidx][fidx] : '0;

  assign merged = word_acc ? wdata :
                  hi_lane  ? {wdata[LANE_W-1:0], cur_word[LANE_W-1:0]} :
                             {cur_word[DATA_W-1:LANE_W], wdata[LANE_W-1:0]};

  assign voice_we = wr_en && is_data && wr_code && run_q;
  assign cnt_we   = wr_en && is_data && (fsel_q == CNT_FUNC);
  assign run_we   = wr_en && is_data && (fsel_q == RUN_FUNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsel_q  <= '0;
      fsel_q  <= '0;
      run_q   <= 1'b0;
      count_q <= CNT_INIT;
    end else begin
      if (wr_en && port_sel == 2'd0) vsel_q <= wdata[SEL_W-1:0];
      if (wr_en && port_sel == 2'd1) fsel_q <= wdata[SEL_W-1:0];
      if (cnt_we) count_q <= wdata[LANE_W-1:0];
      if (run_we) begin
        run_q <= wdata[0];
        if (!wdata[0]) count_q <= CNT_INIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VOICES; v++)
        for (int f = 0; f < NUM_FUNCS; f++)
          mem[v][f] <= '0;
    end else if (voice_we) begin
      mem[vidx][fidx] <= merged;
    end
  end

  always_comb begin
    rdata = '1;
    case (port_sel)
      2'd0: rdata = DATA_W'(vsel_q);
      2'd1: rdata = DATA_W'(fsel_q);
      default: begin
        if (rd_code)
          rdata = word_acc ? cur_word :
                  hi_lane  ? DATA_W'(cur_word[DATA_W-1:LANE_W]) :
                             DATA_W'(cur_word[LANE_W-1:0]);
        else if (fsel_q == CNT_RD)
          rdata = DATA_W'(count_q);
      end
    endcase
  end

  AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_data && wr_code && !run_q) |=> $stable(cur_word)); // R8
  AST_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_we && word_acc) |=> cur_word == $past(wdata)); // R4
  AST_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_we && !word_acc && !hi_lane) |=>
      (cur_word[DATA_W-1:LANE_W] == $past(cur_word[DATA_W-1:LANE_W]) &&
       cur_word[LANE_W-1:0] == $past(wdata[LANE_W-1:0]))); // R5
  AST_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_we && !word_acc && hi_lane) |=>
      (cur_word[LANE_W-1:0] == $past(cur_word[LANE_W-1:0]) &&
       cur_word[DATA_W-1:LANE_W] == $past(wdata[LANE_W-1:0]))); // R6
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count_q == $past(wdata[LANE_W-1:0])); // R9
  AST_COUNT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_we && !wdata[0]) |=> (count_q == CNT_INIT && !run_q)); // R10
endmodule

// File: tb/tb_voice_regfile.sv
module tb_voice_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  port_sel = 2'd0;
  logic        word_acc = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  voice_regfile dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
                     .word_acc(word_acc), .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] p, logic w, logic [15:0] d);
    @(negedge clk);
    port_sel = p; word_acc = w; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] p, logic w, output logic [15:0] q);
    @(negedge clk);
    port_sel = p; word_acc = w;
    #1 q = rdata;
  endtask

  task automatic sel(logic [7:0] v, logic [7:0] f);
    wr(2'd0, 1'b1, {8'h00, v});
    wr(2'd1, 1'b1, {8'h00, f});
  endtask

  task automatic t_reset();
    logic [15:0] q;
    rd(2'd0, 1'b1, q); chk("R1 voice select", q, 16'h0000);
    rd(2'd1, 1'b1, q); chk("R1 function select", q, 16'h0000);
    wr(2'd1, 1'b1, 16'h008E);
    rd(2'd2, 1'b1, q); chk("R1 count", q, 16'h00CD);
    sel(8'h00, 8'h80);
    rd(2'd2, 1'b1, q); chk("R1 storage", q, 16'h0000);
    sel(8'h03, 8'h03);
    wr(2'd2, 1'b1, 16'h1234);
    wr(2'd1, 1'b1, 16'h0083);
    rd(2'd2, 1'b1, q); chk("R8 held after reset", q, 16'h0000);
  endtask

  task automatic t_word();
    logic [15:0] q;
    sel(8'h00, 8'h4C); wr(2'd2, 1'b1, 16'h0001);
    sel(8'h05, 8'h02); wr(2'd2, 1'b1, 16'hBEEF);
    wr(2'd1, 1'b1, 16'h0082);
    rd(2'd1, 1'b1, q); chk("R3 function readback", q, 16'h0082);
    rd(2'd2, 1'b1, q); chk("R4 word readback", q, 16'hBEEF);
    rd(2'd3, 1'b1, q); chk("R4 word from high location", q, 16'hBEEF);
    sel(8'h1F, 8'h0D); wr(2'd3, 1'b1, 16'hA5C3);
    wr(2'd1, 1'b1, 16'h008D);
    rd(2'd2, 1'b1, q); chk("R4 voice 31 function 0x0D", q, 16'hA5C3);
  endtask

  task automatic t_lanes();
    logic [15:0] q;
    sel(8'h05, 8'h02);
    wr(2'd2, 1'b0, 16'h11AA);
    wr(2'd1, 1'b1, 16'h0082);
    rd(2'd2, 1'b1, q); chk("R5 low lane write", q, 16'hBEAA);
    wr(2'd1, 1'b1, 16'h0002);
    wr(2'd3, 1'b0, 16'h2277);
    wr(2'd1, 1'b1, 16'h0082);
    rd(2'd2, 1'b1, q); chk("R6 high lane write", q, 16'h77AA);
    rd(2'd2, 1'b0, q); chk("R7 low byte read", q, 16'h00AA);
    rd(2'd3, 1'b0, q); chk("R7 high byte read", q, 16'h0077);
  endtask

  task automatic t_alias_indep();
    logic [15:0] q;
    sel(8'h06, 8'h02); wr(2'd2, 1'b1, 16'h1111);
    sel(8'h05, 8'h03); wr(2'd2, 1'b1, 16'h2222);
    sel(8'h25, 8'h82);
    rd(2'd0, 1'b1, q); chk("R2 voice select readback", q, 16'h0025);
    rd(2'd2, 1'b1, q); chk("R2 alias voice 0x25 to 5", q, 16'h77AA);
    sel(8'h06, 8'h82);
    rd(2'd2, 1'b1, q); chk("R12 voice 6 function 2", q, 16'h1111);
    sel(8'h05, 8'h83);
    rd(2'd2, 1'b1, q); chk("R12 voice 5 function 3", q, 16'h2222);
    sel(8'h00, 8'h80);
    rd(2'd2, 1'b1, q); chk("R12 voice 0 untouched", q, 16'h0000);
  endtask

  task automatic t_count_unsup();
    logic [15:0] q;
    sel(8'h00, 8'h0E); wr(2'd2, 1'b1, 16'h0020);
    wr(2'd1, 1'b1, 16'h008E);
    rd(2'd2, 1'b1, q); chk("R9 count read low", q, 16'h0020);
    rd(2'd3, 1'b0, q); chk("R9 count read high", q, 16'h0020);
    wr(2'd1, 1'b1, 16'h008F);
    rd(2'd2, 1'b1, q); chk("R11 code 0x8F", q, 16'hFFFF);
    wr(2'd1, 1'b1, 16'h004C);
    rd(2'd2, 1'b1, q); chk("R11 code 0x4C", q, 16'hFFFF);
    wr(2'd1, 1'b1, 16'h0002);
    rd(2'd3, 1'b0, q); chk("R11 write code read", q, 16'hFFFF);
  endtask

  task automatic t_hold();
    logic [15:0] q;
    sel(8'h00, 8'h4C); wr(2'd2, 1'b1, 16'h0000);
    wr(2'd1, 1'b1, 16'h008E);
    rd(2'd2, 1'b1, q); chk("R10 count restored", q, 16'h00CD);
    sel(8'h06, 8'h02); wr(2'd2, 1'b1, 16'hDEAD); wr(2'd3, 1'b0, 16'h0055);
    wr(2'd1, 1'b1, 16'h0082);
    rd(2'd2, 1'b1, q); chk("R8 write dropped while held", q, 16'h1111);
    sel(8'h00, 8'h0E); wr(2'd2, 1'b1, 16'h0007);
    wr(2'd1, 1'b1, 16'h008E);
    rd(2'd2, 1'b1, q); chk("R9 count written while held", q, 16'h0007);
    sel(8'h00, 8'h4C); wr(2'd2, 1'b1, 16'h0001);
    sel(8'h06, 8'h02); wr(2'd2, 1'b1, 16'h4321);
    wr(2'd1, 1'b1, 16'h0082);
    rd(2'd2, 1'b1, q); chk("R10 run bit set again", q, 16'h4321);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word();
    t_lanes();
    t_alias_indep();
    t_count_unsup();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule